// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

This block produces a pulse-width-modulated signal and its complement for driving the high-side and low-side switches of a half-bridge power stage. A free-running timer advances on each tick-enable pulse and restarts once it has reached the programmed period value. The main output is logically active during the first part of each period, as set by the duty value. The complementary output is logically active for the rest of the period.

To keep both switches of a leg from conducting at once, each output holds back its turn-on edge by a programmable number of ticks (0 to 127). Turn-off is immediate. The gap therefore appears on both transitions: each output waits the dead-band time after the other has gone inactive. When the dead-band time is at least as long as an output's logical active interval, that output stays low for the whole period. The period, duty and dead-band inputs are captured into working registers only at a period boundary, so a value written in the middle of a period never produces a short pulse.

Top module: `halfbridge_pwm`

## Requirements
- R1: Both outputs are active-high. Both are low in every cycle while `rst` is high. While `en` is low, both are low from the first clock edge at which `en` is sampled low.
- R2: Timer, working registers and outputs advance only on clock edges where `tick` is high. While `tick` is low, both outputs keep their values.
- R3: With period value P and duty value D, one period lasts P+1 ticks. The main output is logically active for the first D ticks, and the complement for the remaining ticks. D=0 makes the complement logically active all the time. D>P makes the main output logically active all the time.
- R4: An output turns on a number of ticks equal to the dead-band value after its logical turn-on, and turns off with no delay. For 0<D<=P and dead-band value T, the main output is high for max(0, D-T) ticks of each period and the complement for max(0, P+1-D-T) ticks.
- R5: With a dead-band value of 0 and 0<D<=P, the outputs are exact complements. Exactly one of them is high in every steady-state cycle.
- R6: When the dead-band value is not less than an output's logical active interval, that output stays low for the entire period.
- R7: Period, duty and dead-band inputs take effect only at the start of the next period. A change in mid-period leaves the current period's pulse unchanged.
- R8: The two outputs are never high in the same cycle.
- R9: When `tick` pulses on every other clock, every output interval lasts twice as many clock cycles as with `tick` high on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low forces both outputs low and restarts the timer |
| tick | input | 1 | Count enable, one pulse per counting step |
| period_in | input | PER_W | Period value P (period is P+1 ticks) |
| duty_in | input | PER_W | Duty value D in ticks |
| dead_in | input | DB_W | Dead-band delay in ticks |
| out_main | output | 1 | Main PWM output, active-high |
| out_comp | output | 1 | Complementary PWM output, active-high |

## Verification
With `tick` high on every clock, an output edge is registered one clock after the logical edge plus T ticks of delay. A new setting appears only from the first period boundary after it is written. A drop of `en` clears both outputs at the very next edge. The bench drives inputs and samples outputs on falling edges. After each new setting it waits more than two full periods plus the dead-band time, then counts high cycles over exactly one period (or over exactly ten ticks when `tick` runs at half rate), so the counts do not depend on phase. The disable and mid-period-update checks sample at the falling edge right after the edge that is due to act, and the length of each pulse is measured edge to edge.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
  localparam int DEF_PER_W = 8;
  localparam int DEF_DB_W  = 7;

  typedef enum logic {
    LEG_MAIN = 1'b0,
    LEG_COMP = 1'b1
  } leg_e;
endpackage

// File: rtl/hb_timebase.sv
module hb_timebase #(
  parameter int PER_W = hb_pwm_pkg::DEF_PER_W,
  parameter int DB_W  = hb_pwm_pkg::DEF_DB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [PER_W-1:0] period_in,
  input  logic [PER_W-1:0] duty_in,
  input  logic [DB_W-1:0]  dead_in,
  output logic             started,
  output logic             phase_main,
  output logic [DB_W-1:0]  dead_q
);
  logic [PER_W-1:0] tmr;
  logic [PER_W-1:0] tmr_inc;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] duty_q;
  logic             wrap;

  assign tmr_inc = tmr + 1'b1;
  assign wrap    = !started || (tmr == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr        <= '0;
      per_q      <= '0;
      duty_q     <= '0;
      dead_q     <= '0;
      started    <= 1'b0;
      phase_main <= 1'b0;
    end else if (!en) begin
      tmr        <= '0;
      started    <= 1'b0;
      phase_main <= 1'b0;
    end else if (tick) begin
      if (wrap) begin
        tmr        <= '0;
        per_q      <= period_in;
        duty_q     <= duty_in;
        dead_q     <= dead_in;
        started    <= 1'b1;
        phase_main <= (duty_in != '0);
      end else begin
        tmr        <= tmr_inc;
        phase_main <= (tmr_inc < duty_q);
      end
    end
  end

  // R3
  tmr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    started |-> (tmr <= per_q));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !(tick && en && tmr == per_q)) |=> ($stable(duty_q) && $stable(dead_q) && $stable(per_q)));
endmodule

// File: rtl/hb_edge_delay.sv
module hb_edge_delay #(
  parameter int DB_W = hb_pwm_pkg::DEF_DB_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            live,
  input  logic            want,
  input  logic [DB_W-1:0] delay,
  output logic            drive
);
  logic [DB_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      wait_cnt <= '0;
      drive    <= 1'b0;
    end else if (tick) begin
      if (!want) begin
        wait_cnt <= '0;
        drive    <= 1'b0;
      end else if (wait_cnt >= delay) begin
        drive <= 1'b1;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  // R4
  drop_at_once_chk: assert property (@(posedge clk) disable iff (rst)
    (live && tick && !want) |=> !drive);
endmodule

// File: rtl/halfbridge_pwm.sv
module halfbridge_pwm #(
  parameter int PER_W = hb_pwm_pkg::DEF_PER_W,
  parameter int DB_W  = hb_pwm_pkg::DEF_DB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [PER_W-1:0] period_in,
  input  logic [PER_W-1:0] duty_in,
  input  logic [DB_W-1:0]  dead_in,
  output logic             out_main,
  output logic             out_comp
);
  import hb_pwm_pkg::*;

  localparam int LEGS = 2;

  logic            started;
  logic            phase_main;
  logic [DB_W-1:0] dead_q;
  logic            live;
  logic [LEGS-1:0] want;
  logic [LEGS-1:0] drive;

  hb_timebase #(.PER_W(PER_W), .DB_W(DB_W)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick       (tick),
    .period_in  (period_in),
    .duty_in    (duty_in),
    .dead_in    (dead_in),
    .started    (started),
    .phase_main (phase_main),
    .dead_q     (dead_q)
  );

  assign live = started && en;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    if (leg_e'(g) == LEG_MAIN) begin : g_main
      assign want[g] = phase_main;
    end else begin : g_comp
      assign want[g] = !phase_main;
    end

    hb_edge_delay #(.DB_W(DB_W)) u_dly (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .live  (live),
      .want  (want[g]),
      .delay (dead_q),
      .drive (drive[g])
    );
  end

  assign out_main = drive[LEG_MAIN];
  assign out_comp = drive[LEG_COMP];

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_main && out_comp));

  // R1
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!out_main && !out_comp));
endmodule

// File: tb/halfbridge_pwm_tb.sv
`timescale 1ns/1ps
module halfbridge_pwm_tb;
  localparam int PER_W = 8;
  localparam int DB_W  = 7;
  localparam int NV    = 10;
  // {period, duty, dead, expected main high ticks, expected comp high ticks}
  localparam int VEC [NV][5] = '{
    '{ 9,  4,   0,  4,  6},
    '{ 9,  4,   2,  2,  4},
    '{19, 10,   3,  7,  7},
    '{15,  5,   7,  0,  4},
    '{15, 12,   6,  6,  0},
    '{ 7,  0,   2,  0,  8},
    '{ 7,  9,   1,  8,  0},
    '{30, 15, 127,  0,  0},
    '{63, 32,   0, 32, 32},
    '{ 5,  3,   1,  2,  2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic tick = 1'b1;
  logic [PER_W-1:0] period_in = '0;
  logic [PER_W-1:0] duty_in   = '0;
  logic [DB_W-1:0]  dead_in   = '0;
  logic out_main, out_comp;

  int tmode = 0;
  int checks = 0;
  int errors = 0;
  int overlaps = 0;
  bit done = 1'b0;

  halfbridge_pwm #(.PER_W(PER_W), .DB_W(DB_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .period_in(period_in), .duty_in(duty_in), .dead_in(dead_in),
    .out_main(out_main), .out_comp(out_comp)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tmode == 0)      tick <= 1'b1;
    else if (tmode == 1) tick <= ~tick;
    else                 tick <= 1'b0;
    if (!rst && out_main && out_comp) overlaps++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int n, output int ca, output int cb);
    ca = 0;
    cb = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ca += int'(out_main);
      cb += int'(out_comp);
    end
  endtask

  task automatic setup(input int p, input int d, input int t);
    en = 1'b0;
    @(negedge clk);
    period_in = PER_W'(p);
    duty_in   = PER_W'(d);
    dead_in   = DB_W'(t);
    en = 1'b1;
  endtask

  initial begin
    int ca, cb, len;
    bit a0, b0;
    int changes;
    repeat (4) @(negedge clk);
    chk(!out_main && !out_comp, "R1 outputs low in reset", int'(out_main) + int'(out_comp), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_main && !out_comp, "R1 outputs low while disabled", int'(out_main) + int'(out_comp), 0);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][0], VEC[i][1], VEC[i][2]);
      repeat (2 * (VEC[i][0] + 1) + VEC[i][2] + 8) @(negedge clk);
      measure(VEC[i][0] + 1, ca, cb);
      chk(ca == VEC[i][3], $sformatf("R3 R4 R6 main high ticks vec%0d", i), ca, VEC[i][3]);
      chk(cb == VEC[i][4], $sformatf("R3 R4 R6 comp high ticks vec%0d", i), cb, VEC[i][4]);
      if (VEC[i][2] == 0 && VEC[i][1] > 0 && VEC[i][1] <= VEC[i][0])
        chk(ca + cb == VEC[i][0] + 1, $sformatf("R5 exact complement vec%0d", i), ca + cb, VEC[i][0] + 1);
    end

    // R1: drop enable while running
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!out_main && !out_comp, "R1 low one edge after disable", int'(out_main) + int'(out_comp), 0);

    // R2: freeze with tick held low
    setup(9, 4, 0);
    repeat (40) @(negedge clk);
    tmode = 2;
    @(negedge clk);
    a0 = out_main;
    b0 = out_comp;
    changes = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (out_main != a0 || out_comp != b0) changes++;
    end
    chk(changes == 0, "R2 outputs hold while tick low", changes, 0);

    // R9: tick every other cycle
    setup(9, 4, 1);
    tmode = 1;
    repeat (80) @(negedge clk);
    measure(20, ca, cb);
    chk(ca == 6, "R9 main cycles at half tick rate", ca, 6);
    chk(cb == 10, "R9 comp cycles at half tick rate", cb, 10);
    tmode = 0;

    // R7: mid-period duty change
    setup(19, 10, 0);
    repeat (50) @(negedge clk);
    while (out_main) @(negedge clk);
    while (!out_main) @(negedge clk);
    duty_in = 8'd3;
    len = 0;
    while (out_main) begin
      len++;
      @(negedge clk);
    end
    chk(len == 10, "R7 current period keeps old duty", len, 10);
    while (!out_main) @(negedge clk);
    len = 0;
    while (out_main) begin
      len++;
      @(negedge clk);
    end
    chk(len == 3, "R7 next period uses new duty", len, 3);

    chk(overlaps == 0, "R8 outputs never both high", overlaps, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule